// File: doc/BRIEF.md
# RAM Parity Error Address Capture

This block sits beside an internal RAM built from 32-bit words that store one parity bit per byte lane. On every qualified RAM read it checks each lane for even parity, raises a sticky per-lane error flag when a lane fails, and records where the failure happened. Only the first failing word after reset, or after software has cleared every flag, is recorded. Errors that arrive later still raise their lane flags but leave the recorded location alone.

Software reaches two 16-bit registers over a simple bus with a read strobe, a write strobe and a one-bit register select. Select 0 is the status register, which holds the lane flags and is cleared by writing ones. Select 1 is the capture register. It holds the failing word address in bits 14:2, always reads bit 15 as 1 and bits 1:0 as 0, and resets to 8000h. The captured value should only be trusted while at least one flag is set.

Top module: `ram_parity_capture`

## Requirements
- R1: After reset the capture register (regSel=1) reads 8000h and the status register (regSel=0) reads 0000h.
- R2: Parity is even per lane. Lane n covers ramRdData[8n+7:8n] together with ramRdPar[n], and the lane fails when the XOR of those nine bits is 1. Data presented while ramRdValid is low is never checked.
- R3: A lane failure sets status bit n on the clock edge that ends the failing read. The bit then stays set until software clears it.
- R4: When no flag is set, the first failing read loads bits 14:2 of ramRdAddr into capture bits 14:2. This happens on the same edge that sets its flags.
- R5: While any flag is set, further failing reads set their own lane flags but leave the capture register unchanged.
- R6: A status write (regWrEn, regSel=0) clears each flag whose bit in regWrData[3:0] is 1. Zero bits leave their flag alone. Status bits 15:4 always read 0.
- R7: Once all flags are clear, capture re-arms, and the next failing read is recorded.
- R8: When a failing read and a status write happen in the same cycle, the new error's flags are set regardless of the clear. If the write leaves no earlier flag set, the failing address is captured.
- R9: A capture-register write (regWrEn, regSel=1) updates only bits 14:2. Bit 15 reads 1 and bits 1:0 read 0 whatever was written or captured, including when the RAM address bit 15 was 0.
- R10: regRdData shows the selected register combinationally while regRdEn is high, and reads 0000h while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ramRdValid | input | 1 | Qualifies a RAM read cycle |
| ramRdAddr | input | 16 | Byte address of the RAM read |
| ramRdData | input | 32 | Word read from RAM |
| ramRdPar | input | 4 | Stored parity bits, one per byte lane |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regSel | input | 1 | 0 selects status, 1 selects capture address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data |

## Verification
The bench targets the places where capture ordering can go wrong. Several lanes fail while a flag is already set, and a design that keeps re-capturing would show the second address. A clear and a new error land in the same cycle, in two variants: one where the clear empties the register and one where it removes only the failing lane's own flag. A design that lets the clear win would lose the flag, and a design that arms from the old flags would miss the address. The bench also sends corrupted data with the valid strobe low, writes zeros and high-order ones to the status register, and writes all ones and all zeros to the capture register. These catch spurious flags, a missing write-one-to-clear, and fixed bits that follow the write data or the RAM's bit 15.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int REG_W  = 16;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic [LANES-1:0] clrMask;  // write-one-to-clear mask for the flags
    logic             addrWr;   // software write of capture bits
    logic             capture;  // latch the failing address this cycle
  } rpcCtrl_t;
endpackage

// File: rtl/rpc_control.sv
module rpc_control
  import rpc_pkg::*;
(
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  input  logic [LANES-1:0] flagsQ,
  input  logic             anyErr,
  output rpcCtrl_t         ctrl
);
  logic statusWr;
  logic [LANES-1:0] remaining;

  always_comb begin
    statusWr     = regWrEn && !regSel;
    ctrl.clrMask = statusWr ? regWrData[LANES-1:0] : '0;
    ctrl.addrWr  = regWrEn && regSel;
    // flags surviving this cycle's clear decide whether capture is armed
    remaining    = flagsQ & ~ctrl.clrMask;
    ctrl.capture = anyErr && (remaining == '0);
  end
endmodule

// File: rtl/rpc_datapath.sv
module rpc_datapath
  import rpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CAP_LO = 2,
  localparam int DATA_W = LANES * LANE_W,
  localparam int CAP_HI = REG_W - 2,
  localparam int CAP_W  = CAP_HI - CAP_LO + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ramRdValid,
  input  logic [ADDR_W-1:0] ramRdAddr,
  input  logic [DATA_W-1:0] ramRdData,
  input  logic [LANES-1:0]  ramRdPar,
  input  rpcCtrl_t          ctrl,
  input  logic              regRdEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [LANES-1:0]  flagsQ,
  output logic [CAP_W-1:0]  addrQ,
  output logic              anyErr,
  output logic [REG_W-1:0]  regRdData
);
  logic [LANES-1:0] laneErr;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneErr[i] = ramRdValid && (^{ramRdData[i*LANE_W +: LANE_W], ramRdPar[i]});
  end

  assign anyErr = |laneErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (flagsQ & ~ctrl.clrMask) | laneErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrQ <= '0;
    else if (ctrl.capture) addrQ <= ramRdAddr[CAP_HI:CAP_LO];
    else if (ctrl.addrWr)  addrQ <= regWrData[CAP_HI:CAP_LO];
  end

  logic [REG_W-1:0] addrView, statusView;
  always_comb begin
    addrView   = {1'b1, addrQ, {CAP_LO{1'b0}}};
    statusView = {{(REG_W-LANES){1'b0}}, flagsQ};
    regRdData  = !regRdEn ? '0 : (regSel ? addrView : statusView);
  end
endmodule

// File: rtl/ram_parity_capture.sv
module ram_parity_capture
  import rpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CAP_LO = 2,
  localparam int DATA_W = LANES * LANE_W,
  localparam int CAP_W  = REG_W - 2 - CAP_LO + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ramRdValid,
  input  logic [ADDR_W-1:0] ramRdAddr,
  input  logic [DATA_W-1:0] ramRdData,
  input  logic [LANES-1:0]  ramRdPar,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData
);
  rpcCtrl_t         ctrl;
  logic [LANES-1:0] flagsQ;
  logic [CAP_W-1:0] addrQ;
  logic             anyErr;

  rpc_control u_ctrl (
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .flagsQ(flagsQ), .anyErr(anyErr), .ctrl(ctrl)
  );

  rpc_datapath #(.ADDR_W(ADDR_W), .CAP_LO(CAP_LO)) u_dp (
    .clk(clk), .rstN(rstN), .ramRdValid(ramRdValid), .ramRdAddr(ramRdAddr),
    .ramRdData(ramRdData), .ramRdPar(ramRdPar), .ctrl(ctrl),
    .regRdEn(regRdEn), .regSel(regSel), .regWrData(regWrData),
    .flagsQ(flagsQ), .addrQ(addrQ), .anyErr(anyErr), .regRdData(regRdData)
  );
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker
  import rpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CAP_LO = 2,
  localparam int DATA_W = LANES * LANE_W,
  localparam int CAP_W  = REG_W - 2 - CAP_LO + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              ramRdValid,
  input logic [ADDR_W-1:0] ramRdAddr,
  input logic [DATA_W-1:0] ramRdData,
  input logic [LANES-1:0]  ramRdPar,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic              regSel,
  input logic [REG_W-1:0]  regRdData,
  input logic [LANES-1:0]  flagsQ,
  input logic [CAP_W-1:0]  addrQ
);
  logic seenErr;
  always_comb begin
    seenErr = 1'b0;
    for (int i = 0; i < LANES; i++)
      seenErr = seenErr | (^{ramRdData[i*LANE_W +: LANE_W], ramRdPar[i]});
    seenErr = seenErr && ramRdValid;
  end

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |-> regRdData == '0);

  p_fixed_bits_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regSel) |-> (regRdData[REG_W-1] && regRdData[CAP_LO-1:0] == '0));

  p_first_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ == '0 && seenErr && !regWrEn) |=>
      (addrQ == $past(ramRdAddr[REG_W-2:CAP_LO]) && flagsQ != '0));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ != '0 && !regWrEn) |=> $stable(addrQ));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ((flagsQ & $past(flagsQ)) == $past(flagsQ)));

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ramRdValid |=> ((flagsQ & ~$past(flagsQ)) == '0));
endmodule

bind ram_parity_capture rpc_checker #(.ADDR_W(ADDR_W), .CAP_LO(CAP_LO)) u_chk (
  .clk(clk), .rstN(rstN), .ramRdValid(ramRdValid), .ramRdAddr(ramRdAddr),
  .ramRdData(ramRdData), .ramRdPar(ramRdPar), .regWrEn(regWrEn),
  .regRdEn(regRdEn), .regSel(regSel), .regRdData(regRdData),
  .flagsQ(flagsQ), .addrQ(addrQ)
);

// File: tb/ram_parity_capture_bench.sv
module ram_parity_capture_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ramRdValid = 1'b0;
  logic [15:0] ramRdAddr = '0;
  logic [31:0] ramRdData = '0;
  logic [3:0]  ramRdPar = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic        regSel = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;

  always #4 clk = ~clk;  // 125 MHz

  ram_parity_capture u_ram_parity_capture (.*);

  typedef struct { logic sel; logic [15:0] exp; string req; } item_t;
  item_t sbq[$];
  int compared = 0, mismatched = 0;
  bit finished = 0;

  // bench model, written from the requirements
  logic [3:0]  mFlags = '0;
  logic [15:0] mAddr  = 16'h8000;

  function automatic logic [3:0] goodPar(input logic [31:0] d);
    for (int i = 0; i < 4; i++) goodPar[i] = ^d[i*8 +: 8];
  endfunction

  task automatic drive(input logic v, input logic [15:0] a, input logic [31:0] d,
                       input logic [3:0] p, input logic we, input logic re,
                       input logic sel, input logic [15:0] wd);
    @(posedge clk); #2;
    ramRdValid = v; ramRdAddr = a; ramRdData = d; ramRdPar = p;
    regWrEn = we; regRdEn = re; regSel = sel; regWrData = wd;
  endtask

  task automatic idle();
    drive(0, '0, '0, '0, 0, 0, 0, '0);
  endtask

  // one cycle: RAM read with lanes in badMask corrupted, plus optional status clear
  task automatic ramRead(input logic [15:0] a, input logic [31:0] d,
                         input logic [3:0] badMask, input logic clr, input logic [3:0] clrMask);
    logic [3:0] rem;
    drive(1, a, d, goodPar(d) ^ badMask, clr, 0, 0, {12'h000, clrMask});
    rem = mFlags & ~(clr ? clrMask : 4'h0);
    if (badMask != 0 && rem == 0) mAddr = {1'b1, a[14:2], 2'b00};
    mFlags = rem | badMask;
  endtask

  task automatic regWrite(input logic sel, input logic [15:0] wd);
    drive(0, '0, '0, '0, 1, 0, sel, wd);
    if (sel) mAddr = {1'b1, wd[14:2], 2'b00};
    else     mFlags = mFlags & ~wd[3:0];
  endtask

  task automatic expectRead(input logic sel, input string req);
    item_t it;
    it.sel = sel; it.req = req;
    it.exp = sel ? mAddr : {12'h000, mFlags};
    sbq.push_back(it);
    drive(0, '0, '0, '0, 0, 1, sel, '0);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (rstN && regRdEn) begin
      item_t it;
      if (sbq.size() == 0) begin
        mismatched++;
        $display("FAIL R10: unexpected read, actual %h expected none", regRdData);
      end else begin
        it = sbq.pop_front();
        compared++;
        if (regRdData !== it.exp) begin
          mismatched++;
          $display("FAIL %s: sel=%0d actual %h expected %h", it.req, it.sel, regRdData, it.exp);
        end
      end
    end
  end

  task automatic checkIdleZero();
    drive(0, '0, '0, '0, 0, 0, 1, '0);
    @(negedge clk);
    compared++;
    if (regRdData !== 16'h0000) begin
      mismatched++;
      $display("FAIL R10: idle read data actual %h expected 0000", regRdData);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    expectRead(1, "R1");                              // 8000
    expectRead(0, "R1");                              // 0000
    ramRead(16'h0040, 32'hDEADBEEF, 4'h0, 0, 4'h0);   // clean read
    expectRead(0, "R2");
    drive(0, 16'h0044, 32'h000000FF, 4'hF, 0, 0, 0, '0); // bad parity, not valid
    expectRead(0, "R2");
    ramRead(16'h0ABF, 32'h12345678, 4'h4, 0, 4'h0);   // lane 2 fails
    expectRead(0, "R3");                              // 0004
    expectRead(1, "R4");                              // 8ABC
    ramRead(16'h1234, 32'hCAFEF00D, 4'h3, 0, 4'h0);   // lanes 0,1 while armed off
    expectRead(0, "R5");                              // 0007
    expectRead(1, "R5");                              // still 8ABC
    regWrite(0, 16'h0000);
    expectRead(0, "R6");                              // 0007
    regWrite(0, 16'hFFF3);
    expectRead(0, "R6");                              // 0004, high bits ignored
    regWrite(0, 16'h0004);
    expectRead(0, "R6");                              // 0000
    ramRead(16'h7FF8, 32'h00000000, 4'h8, 0, 4'h0);   // re-armed, lane 3
    expectRead(1, "R7");                              // FFF8
    expectRead(0, "R7");                              // 0008
    ramRead(16'h0100, 32'h55AA55AA, 4'h2, 1, 4'h8);   // clear empties + new error
    expectRead(0, "R8");                              // 0002
    expectRead(1, "R8");                              // 8100
    ramRead(16'h0300, 32'h0F0F0F0F, 4'h2, 1, 4'h2);   // clear own lane + error
    expectRead(0, "R8");                              // 0002
    expectRead(1, "R8");                              // 8300
    regWrite(1, 16'h7FFF);
    expectRead(1, "R9");                              // FFFC
    regWrite(1, 16'h0000);
    expectRead(1, "R9");                              // 8000
    checkIdleZero();
    idle();
    idle();
    if (sbq.size() != 0) begin
      mismatched++;
      $display("FAIL R10: %0d reads unanswered, expected 0", sbq.size());
    end
    summary();
  end
endmodule